// File: doc/BRIEF.md
# Extrinsic Product Forward-Backward Unit

This block serves one check node of a non-binary belief-propagation decoder working in the probability domain. A frame of d message vectors arrives one per cycle. Each vector holds Q unsigned fractions of WPE bits. For every position n of the frame, the block returns the element-wise product of all the other vectors in the frame. Vector n is left out of its own product. The block never divides. It builds a running prefix product while the frame arrives, then a suffix product walking backwards, and combines the two for each position.

Each result vector is renormalised before it leaves. A single left shift, shared by all lanes of the vector, brings the largest element into [0.5, 1). The top WP bits of each lane are then kept. One vector multiplier, with Q parallel lanes, is shared by the collect, backward and output phases. The frame length is taken at run time from the stream markers, up to a parameter limit.

Top module: `ext_prod_fb`

## Requirements
- R1: A frame starts only on a valid input with `in_first_i` set. Such an input is accepted while the block is idle or collecting, and it restarts the frame at position 0. Valid inputs without `in_first_i` while the block is idle are ignored.
- R2: The product of two elements is ⊗, defined as floor(a·b / 2^WPE) per lane. The prefix chain is f0 = x0 and fk = f(k-1) ⊗ xk. The suffix chain is b(d-1) = x(d-1) and bk = xk ⊗ b(k+1). For an interior position n, the raw result is f(n-1) ⊗ b(n+1).
- R3: The raw result for position 0 is b1. The raw result for position d-1 is f(d-2).
- R4: Each output lane equals the raw lane shifted left by s, keeping its top WP bits of WPE. Here s is the number of leading zeros of the largest raw lane in the vector. So when any lane is nonzero, at least one output lane has its top bit set.
- R5: A raw vector whose lanes are all zero is output as all zeros.
- R6: Suppose the last input of a frame of degree d is accepted at clock edge E. Then `out_valid_o` is high from edge E+d-2 for exactly d consecutive cycles, delivering positions 0 to d-1 in order. `out_first_o` marks position 0, `out_last_o` marks position d-1, and `out_valid_o` falls after the last one.
- R7: Inputs presented while the block computes the suffix chain or emits results are ignored and do not change the results.
- R8: A frame closes on `in_last_i` or when it reaches MAX_DEG vectors, whichever comes first.
- R9: A frame whose first vector also carries `in_last_i` is dropped and produces no output.
- R10: After reset `out_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input vector valid |
| in_first_i | input | 1 | Input vector is position 0 of a frame |
| in_last_i | input | 1 | Input vector closes the frame |
| in_vec_i | input | Q*WPE | Q unsigned Q0.WPE fractions, lane l at bits [l*WPE +: WPE] |
| out_valid_o | output | 1 | Output vector valid |
| out_first_o | output | 1 | Output is position 0 |
| out_last_o | output | 1 | Output is position d-1 |
| out_vec_o | output | Q*WP | Normalised results, lane l at bits [l*WP +: WP] |

## Verification
The first result of a degree-d frame is due d-2 edges after the edge that accepts the last input. It is then followed by one vector per cycle. The bench drives inputs and samples outputs on the falling edge. After the last input it counts falling edges until `out_valid_o` rises and compares that count with d-2. It then checks each of the d positions on successive falling edges, with its markers and the exact value worked out from the truncated chains. Finally it checks that valid drops on the next cycle. Dropped frames, ignored inputs and the all-zero case are judged over a fixed window of cycles on the same edges.

// File: rtl/ext_prod_pkg.sv
package ext_prod_pkg;
  typedef enum logic [1:0] {EP_IDLE, EP_COLL, EP_BWD, EP_OUT} ep_state_e;
endpackage

// File: rtl/ext_prod_vmul.sv
module ext_prod_vmul #(
  parameter int unsigned Q = 4,
  parameter int unsigned W = 20
) (
  input  logic [Q*W-1:0] a_i,
  input  logic [Q*W-1:0] b_i,
  output logic [Q*W-1:0] p_o
);
  localparam int unsigned W2 = 2 * W;

  for (genvar l = 0; l < Q; l++) begin : g_lane
    // Q0.W x Q0.W, truncated back to W fraction bits
    assign p_o[l*W +: W] = W'((W2'(a_i[l*W +: W]) * W2'(b_i[l*W +: W])) >> W);
  end
endmodule

// File: rtl/ext_prod_norm.sv
module ext_prod_norm #(
  parameter int unsigned Q  = 4,
  parameter int unsigned WI = 20,
  parameter int unsigned WO = 14
) (
  input  logic [Q*WI-1:0] vec_i,
  output logic [Q*WO-1:0] vec_o
);
  localparam int unsigned SW = $clog2(WI);

  logic [WI-1:0] mx;
  logic [SW-1:0] sh;

  always_comb begin
    mx = '0;
    for (int l = 0; l < Q; l++)
      if (vec_i[l*WI +: WI] > mx) mx = vec_i[l*WI +: WI];
    sh = '0;
    for (int i = 0; i < WI; i++)
      if (mx[i]) sh = SW'(WI - 1 - i);
  end

  for (genvar l = 0; l < Q; l++) begin : g_lane
    assign vec_o[l*WO +: WO] = WO'(WI'(vec_i[l*WI +: WI] << sh) >> (WI - WO));
  end
endmodule

// File: rtl/ext_prod_fb.sv
module ext_prod_fb
  import ext_prod_pkg::*;
#(
  parameter int unsigned Q       = 4,
  parameter int unsigned WPE     = 20,
  parameter int unsigned WP      = 14,
  parameter int unsigned MAX_DEG = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_first_i,
  input  logic              in_last_i,
  input  logic [Q*WPE-1:0]  in_vec_i,
  output logic              out_valid_o,
  output logic              out_first_o,
  output logic              out_last_o,
  output logic [Q*WP-1:0]   out_vec_o
);
  localparam int unsigned VW = Q * WPE;
  localparam int unsigned AW = $clog2(MAX_DEG);
  localparam int unsigned IW = $clog2(MAX_DEG + 1);
  localparam logic [AW-1:0] LAST_SLOT = AW'(MAX_DEG - 1);

  ep_state_e     state_q;
  logic [AW-1:0] pos_q, k_q;
  logic [IW-1:0] deg_q;

  logic [VW-1:0] x_q   [MAX_DEG];
  logic [VW-1:0] fwd_q [MAX_DEG];
  logic [VW-1:0] bwd_q [MAX_DEG];

  logic [VW-1:0] mul_a, mul_b, prod, ext;
  logic          accept, close;
  logic [AW-1:0] wpos, wpm1, km1, kp1, klast;

  always_comb begin
    accept = in_valid_i && ((state_q == EP_IDLE && in_first_i) || state_q == EP_COLL);
    wpos   = in_first_i ? '0 : pos_q;
    close  = in_last_i || (wpos == LAST_SLOT);
    wpm1   = (wpos == '0) ? '0 : wpos - 1'b1;
    km1    = (k_q == '0) ? '0 : k_q - 1'b1;
    kp1    = (k_q == LAST_SLOT) ? k_q : k_q + 1'b1;
    klast  = AW'(deg_q - 1'b1);
    // one shared multiplier, operands picked by phase
    unique case (state_q)
      EP_BWD: begin mul_a = x_q[k_q];   mul_b = bwd_q[kp1]; end
      EP_OUT: begin mul_a = fwd_q[km1]; mul_b = bwd_q[kp1]; end
      default: begin mul_a = in_vec_i;  mul_b = fwd_q[wpm1]; end
    endcase
    if (k_q == '0)        ext = bwd_q[1];
    else if (k_q == klast) ext = fwd_q[km1];
    else                   ext = prod;
  end

  ext_prod_vmul #(.Q(Q), .W(WPE)) i_vmul (
    .a_i (mul_a),
    .b_i (mul_b),
    .p_o (prod)
  );

  ext_prod_norm #(.Q(Q), .WI(WPE), .WO(WP)) i_norm (
    .vec_i (ext),
    .vec_o (out_vec_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EP_IDLE;
      pos_q   <= '0;
      k_q     <= '0;
      deg_q   <= '0;
    end else begin
      unique case (state_q)
        EP_IDLE, EP_COLL: begin
          if (accept) begin
            if (close) begin
              if (wpos == '0) begin
                state_q <= EP_IDLE;  // one-vector frame dropped
              end else begin
                deg_q <= IW'(wpos) + 1'b1;
                if (wpos > 1) begin
                  state_q <= EP_BWD;
                  k_q     <= wpos - 1'b1;
                end else begin
                  state_q <= EP_OUT;
                  k_q     <= '0;
                end
              end
            end else begin
              state_q <= EP_COLL;
              pos_q   <= wpos + 1'b1;
            end
          end
        end
        EP_BWD: begin
          if (k_q == AW'(1)) begin
            state_q <= EP_OUT;
            k_q     <= '0;
          end else begin
            k_q <= k_q - 1'b1;
          end
        end
        EP_OUT: begin
          if (k_q == klast) state_q <= EP_IDLE;
          k_q <= k_q + 1'b1;
        end
        default: state_q <= EP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept) begin
      x_q[wpos]   <= in_vec_i;
      fwd_q[wpos] <= (wpos == '0) ? in_vec_i : prod;
      if (close) bwd_q[wpos] <= in_vec_i;
    end
    if (state_q == EP_BWD) bwd_q[k_q] <= prod;
  end

  assign out_valid_o = (state_q == EP_OUT);
  assign out_first_o = out_valid_o && (k_q == '0);
  assign out_last_o  = out_valid_o && (k_q == klast);

  logic any_msb;
  always_comb begin
    any_msb = 1'b0;
    for (int l = 0; l < Q; l++) any_msb = any_msb | out_vec_o[l*WP + WP - 1];
  end

  assert_norm_msb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (|out_vec_o)) |-> any_msb);
  assert_first_on_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_first_o);
  assert_burst_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |=> out_valid_o);
  assert_burst_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |=> !out_valid_o);
  assert_busy_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == EP_BWD || state_q == EP_OUT) |=> $stable(deg_q));
  assert_deg_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deg_q <= IW'(MAX_DEG));
endmodule

// File: tb/test_ext_prod_fb.sv
`timescale 1ns/1ps
module test_ext_prod_fb;
  localparam int Q = 4, WPE = 20, WP = 14, MAX_DEG = 8;
  localparam int VW = Q * WPE, OW = Q * WP;
  localparam int NF = 8;
  // {degree, seed, kind, drop_last}; kind 0 large, 1 small, 2 first two all-zero
  localparam int FR [NF][4] = '{
    '{2, 1, 0, 0}, '{3, 2, 0, 0}, '{5, 3, 0, 0}, '{8, 4, 0, 1},
    '{4, 5, 1, 0}, '{6, 6, 1, 0}, '{3, 7, 2, 0}, '{7, 8, 0, 0}};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_first = 0, in_last = 0;
  logic [VW-1:0] in_vec = '0;
  logic out_valid, out_first, out_last;
  logic [OW-1:0] out_vec;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_prod_fb #(.Q(Q), .WPE(WPE), .WP(WP), .MAX_DEG(MAX_DEG)) i_ext_prod_fb (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_first_i(in_first),
    .in_last_i(in_last), .in_vec_i(in_vec), .out_valid_o(out_valid),
    .out_first_o(out_first), .out_last_o(out_last), .out_vec_o(out_vec));

  logic [WPE-1:0] xm [MAX_DEG][Q];
  logic [WPE-1:0] fw [MAX_DEG][Q];
  logic [WPE-1:0] bw [MAX_DEG][Q];
  logic [OW-1:0]  ev [MAX_DEG];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [WPE-1:0] fmul(input logic [WPE-1:0] a, input logic [WPE-1:0] b);
    logic [2*WPE-1:0] p;
    p = {{WPE{1'b0}}, a} * {{WPE{1'b0}}, b};
    return p[2*WPE-1:WPE];
  endfunction

  function automatic logic [WPE-1:0] gen(input int seed, input int n, input int a, input int kind);
    logic [31:0] h;
    h = 32'(seed) * 32'd40503 + 32'(n) * 32'd9973 + 32'(a) * 32'd613 + 32'd1;
    h = h ^ (h >> 13);
    h = h * 32'h5bd1e995;
    h = h ^ (h >> 15);
    if (kind == 2 && n < 2) return '0;
    if (kind == 1) return h[WPE-1:0] >> 5;
    return h[WPE-1:0] | (1 << (WPE - 1));
  endfunction

  task automatic build(input int d, input int seed, input int kind);
    logic [WPE-1:0] raw [Q];
    logic [WPE-1:0] mx;
    int s;
    for (int n = 0; n < d; n++)
      for (int a = 0; a < Q; a++) xm[n][a] = gen(seed, n, a, kind);
    for (int a = 0; a < Q; a++) begin
      fw[0][a] = xm[0][a];
      for (int n = 1; n < d; n++) fw[n][a] = fmul(fw[n-1][a], xm[n][a]);
      bw[d-1][a] = xm[d-1][a];
      for (int n = d - 2; n >= 0; n--) bw[n][a] = fmul(xm[n][a], bw[n+1][a]);
    end
    for (int n = 0; n < d; n++) begin
      mx = '0;
      for (int a = 0; a < Q; a++) begin
        if (n == 0) raw[a] = bw[1][a];
        else if (n == d - 1) raw[a] = fw[d-2][a];
        else raw[a] = fmul(fw[n-1][a], bw[n+1][a]);
        if (raw[a] > mx) mx = raw[a];
      end
      s = 0;
      if (mx != 0) while (!mx[WPE-1]) begin mx = mx << 1; s++; end
      for (int a = 0; a < Q; a++) ev[n][a*WP +: WP] = WP'(WPE'(raw[a] << s) >> (WPE - WP));
    end
  endtask

  task automatic run_frame(input int d, input int seed, input int kind, input bit nolast, input bit jam);
    int w;
    string tag;
    build(d, seed, kind);
    for (int n = 0; n < d; n++) begin
      @(negedge clk);
      in_valid = 1; in_first = (n == 0); in_last = (n == d - 1) && !nolast;
      for (int a = 0; a < Q; a++) in_vec[a*WPE +: WPE] = xm[n][a];
    end
    @(negedge clk);
    if (jam) begin in_valid = 1; in_first = 1; in_last = 0; in_vec = '1; end
    else begin in_valid = 0; in_first = 0; in_last = 0; end
    w = 0;
    while (!out_valid && w < 40) begin @(negedge clk); w++; end
    chk(w == d - 2, "R6 latency", 64'(w), 64'(d - 2));
    for (int n = 0; n < d; n++) begin
      if (jam && n == d - 1) begin in_valid = 0; in_first = 0; end
      tag = (kind == 2) ? "R5 zero vector" : (n == 0 || n == d - 1) ? "R3 end position" :
            (jam ? "R7 busy inputs" : "R2 interior");
      chk(out_valid, "R6 valid burst", 64'(out_valid), 64'd1);
      chk(out_first == (n == 0) && out_last == (n == d - 1), "R6 markers",
          64'({out_first, out_last}), 64'({n == 0, n == d - 1}));
      chk(out_vec == ev[n], tag, 64'(out_vec), 64'(ev[n]));
      @(negedge clk);
    end
    chk(!out_valid, "R6 valid falls", 64'(out_valid), 64'd0);
    in_valid = 0; in_first = 0; in_last = 0;
  endtask

  task automatic quiet(input int cycles, input string req);
    bit seen = 0;
    for (int c = 0; c < cycles; c++) begin @(negedge clk); if (out_valid) seen = 1; end
    chk(!seen, req, 64'(seen), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid, "R10 reset", 64'(out_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid, "R10 after reset", 64'(out_valid), 64'd0);

    for (int f = 0; f < NF; f++) run_frame(FR[f][0], FR[f][1], FR[f][2], FR[f][3] != 0, 1'b0);

    // R8: a frame without last is closed at MAX_DEG (row 3 has drop_last); checked again here
    run_frame(MAX_DEG, 11, 1, 1'b1, 1'b0);

    // R1: vectors without first while idle are ignored
    for (int n = 0; n < 3; n++) begin
      @(negedge clk); in_valid = 1; in_first = 0; in_last = (n == 2); in_vec = '1;
    end
    @(negedge clk); in_valid = 0; in_last = 0;
    quiet(12, "R1 no start without first");

    // R9: single-vector frame dropped
    @(negedge clk); in_valid = 1; in_first = 1; in_last = 1; in_vec = '1;
    @(negedge clk); in_valid = 0; in_first = 0; in_last = 0;
    quiet(12, "R9 single vector dropped");

    // R1: a partial frame is restarted by a new first
    for (int n = 0; n < 2; n++) begin
      @(negedge clk); in_valid = 1; in_first = (n == 0); in_last = 0; in_vec = '1;
    end
    run_frame(4, 21, 0, 1'b0, 1'b0);
    chk(1'b1, "R1 restart on first", 64'd0, 64'd0);

    // R7: inputs driven during backward and output phases are ignored
    run_frame(5, 31, 0, 1'b0, 1'b1);
    run_frame(2, 32, 1, 1'b0, 1'b1);
    quiet(8, "R7 no frame from busy inputs");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule